// File: doc/BRIEF.md
# Latency-Hiding Shift-Register Accumulator

This block reduces a stream of integer operands to a single sum while feeding them through a pipelined adder whose result only becomes usable several cycles after issue. A plain running total would have to wait out the full adder latency between operands, because each addition needs the previous total. Here the block keeps a ring of independent partial sums instead. Each accepted operand is added to the slot it lands on, and the ring advances by one position per operand, so back-to-back operands never depend on one another. The ring is at least as deep as the adder latency, so a slot's updated value is back before that slot comes round again.

Operands arrive on a valid/ready stream with a last flag marking the final operand of a reduction. Once the last operand is taken, the input closes. The block then folds the slots pairwise through the same adder, halving the number of live slots each round. It waits for the adder to drain before each round and before presenting the result. The result is held with a valid flag until the consumer accepts it. The slots are cleared on acceptance, so the next reduction can begin on the following cycle. Arithmetic wraps modulo 2^WIDTH.

Top module: `lat_hide_accum`

## Requirements
- R1: After reset, and after a reset applied in the middle of a reduction, `sum_valid` is 0 and `op_ready` is 1, and no earlier operand contributes to the next result.
- R2: The result equals the sum of all operands of the reduction, modulo 2^WIDTH.
- R3: While a reduction is accumulating, `op_ready` stays 1 on every cycle, so one operand is accepted per clock with no stall.
- R4: From the cycle after the operand with `op_last` is accepted, `op_ready` is 0 until the result has been accepted.
- R5: While `sum_valid` is 1 and `sum_ready` is 0, `sum_valid` stays 1 and `sum_data` does not change.
- R6: A reduction of exactly one operand returns that operand unchanged.
- R7: In the cycle after a handshake with `sum_valid` and `sum_ready` both 1, `sum_valid` is 0 and `op_ready` is 1. All partial sums are zero at that point.
- R8: Cycles with `op_valid` at 0 in the middle of a reduction add nothing to the result.
- R9: Reductions longer than the slot count, and reductions of exactly the slot count, give the correct sum.
- R10: `sum_valid` rises no sooner than LATENCY cycles after the last operand is accepted, and only when the adder pipeline is empty. With the default parameters it rises within 64 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand present |
| op_ready | output | 1 | Block can take an operand this cycle |
| op_data | input | WIDTH | Operand value |
| op_last | input | 1 | Operand is the final one of the reduction |
| sum_valid | output | 1 | Result available |
| sum_ready | input | 1 | Consumer takes the result |
| sum_data | output | WIDTH | Reduction result |

## Verification
A slot updated at the wrong time or lost in the ring, such as a write-back that lands after the slot is read again, shows up only as a wrong `sum_data`. It appears at the end of the reduction, usually when the run is longer than the slot count or exactly equal to it. A missing clear shows up as a second result carrying the first one's total, on the next result after the restart. Sequencing faults show at the handshake pins within a cycle or two. Examples are `op_ready` reopening during the fold, `sum_valid` dropping before acceptance, or the result appearing before the adder drains.

// File: rtl/lha_pkg.sv
package lha_pkg;
  // Sequencer phases: take operands, wait for adder to empty, fold one round, present result
  typedef enum logic [1:0] {
    ST_ACC   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FOLD  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/lha_add_pipe.sv
module lha_add_pipe #(
  parameter int WIDTH = 32,
  parameter int LAT   = 7,
  parameter int TW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [TW-1:0]    in_tag,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_sum,
  output logic [TW-1:0]    out_tag,
  output logic             busy
);
  // modular addition kept in one place so its meaning is explicit
  function automatic logic [WIDTH-1:0] wrap_add(input logic [WIDTH-1:0] a,
                                                input logic [WIDTH-1:0] b);
    return a + b;
  endfunction

  logic [LAT-1:0]   vld_q;
  logic [WIDTH-1:0] dat_q [LAT];
  logic [TW-1:0]    tag_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q[0] <= in_vld;
      for (int i = 1; i < LAT; i++) vld_q[i] <= vld_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    dat_q[0] <= wrap_add(in_a, in_b);
    tag_q[0] <= in_tag;
    for (int i = 1; i < LAT; i++) begin
      dat_q[i] <= dat_q[i-1];
      tag_q[i] <= tag_q[i-1];
    end
  end

  assign out_vld = vld_q[LAT-1];
  assign out_sum = dat_q[LAT-1];
  assign out_tag = tag_q[LAT-1];
  assign busy    = |vld_q;

  // R10
  issue_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> busy);
endmodule

// File: rtl/lha_slot_bank.sv
module lha_slot_bank #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wb_vld,
  input  logic [IW-1:0]    wb_idx,
  input  logic [WIDTH-1:0] wb_dat,
  input  logic [IW-1:0]    ra_idx,
  input  logic [IW-1:0]    rb_idx,
  output logic [WIDTH-1:0] ra_dat,
  output logic [WIDTH-1:0] rb_dat,
  output logic [WIDTH-1:0] head_dat,
  output logic             all_zero
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (wb_vld) begin
      slot_q[wb_idx] <= wb_dat;
    end
  end

  // forward a write-back that lands on the slot being read this cycle
  always_comb begin
    ra_dat = (wb_vld && wb_idx == ra_idx) ? wb_dat : slot_q[ra_idx];
    rb_dat = (wb_vld && wb_idx == rb_idx) ? wb_dat : slot_q[rb_idx];
  end

  assign head_dat = slot_q[0];

  always_comb begin
    all_zero = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      if (slot_q[i] != '0) all_zero = 1'b0;
  end

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> all_zero);
endmodule

// File: rtl/lha_sequencer.sv
module lha_sequencer
  import lha_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = 3,
  parameter int HW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_last,
  input  logic          pipe_busy,
  input  logic          sum_ready,
  output logic          op_ready,
  output logic          sum_valid,
  output logic          iss_vld,
  output logic          iss_fold,
  output logic [IW-1:0] rd_a_idx,
  output logic [IW-1:0] rd_b_idx,
  output logic          clr
);
  localparam logic [HW-1:0] HALF0    = HW'(DEPTH / 2);
  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  seq_state_e    st_q;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] idx_q;
  logic [HW-1:0] half_q;
  logic [HW-1:0] partner;
  logic          accept;
  logic          round_end;

  assign partner   = HW'(idx_q) + half_q;
  assign accept    = (st_q == ST_ACC) && op_valid;
  assign round_end = (HW'(idx_q) == half_q - HW'(1));

  always_comb begin
    op_ready  = (st_q == ST_ACC);
    sum_valid = (st_q == ST_DONE);
    iss_vld   = 1'b0;
    iss_fold  = 1'b0;
    rd_a_idx  = '0;
    rd_b_idx  = '0;
    clr       = 1'b0;
    unique case (st_q)
      ST_ACC: begin
        iss_vld  = accept;
        rd_a_idx = ptr_q;
      end
      ST_FOLD: begin
        iss_vld  = 1'b1;
        iss_fold = 1'b1;
        rd_a_idx = idx_q;
        rd_b_idx = partner[IW-1:0];
      end
      ST_DONE:  clr = sum_ready;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_ACC;
      ptr_q  <= '0;
      idx_q  <= '0;
      half_q <= '0;
    end else begin
      unique case (st_q)
        ST_ACC: if (accept) begin
          ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + IW'(1);
          if (op_last) begin
            st_q   <= ST_DRAIN;
            half_q <= HALF0;
            idx_q  <= '0;
          end
        end
        ST_DRAIN: if (!pipe_busy) begin
          st_q  <= (half_q == '0) ? ST_DONE : ST_FOLD;
          idx_q <= '0;
        end
        ST_FOLD: begin
          if (round_end) begin
            half_q <= half_q >> 1;
            st_q   <= ST_DRAIN;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        ST_DONE: if (sum_ready) begin
          st_q  <= ST_ACC;
          ptr_q <= '0;
        end
        default: st_q <= ST_ACC;
      endcase
    end
  end

  // R4
  fold_without_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fold |-> !accept);
endmodule

// File: rtl/lat_hide_accum.sv
module lat_hide_accum #(
  parameter int WIDTH   = 32,
  parameter int LATENCY = 7,
  parameter int DEPTH   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [WIDTH-1:0] op_data,
  input  logic             op_last,
  output logic             sum_valid,
  input  logic             sum_ready,
  output logic [WIDTH-1:0] sum_data
);
  // DEPTH must be a power of two and at least LATENCY
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int HW = $clog2(DEPTH) + 1;

  logic             iss_vld, iss_fold, clr, pipe_busy, all_zero;
  logic [IW-1:0]    rd_a_idx, rd_b_idx, wb_idx;
  logic [WIDTH-1:0] ra_dat, rb_dat, wb_dat, add_b;
  logic             wb_vld;

  lha_sequencer #(.DEPTH(DEPTH), .IW(IW), .HW(HW)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_last(op_last),
    .pipe_busy(pipe_busy), .sum_ready(sum_ready), .op_ready(op_ready),
    .sum_valid(sum_valid), .iss_vld(iss_vld), .iss_fold(iss_fold),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .clr(clr)
  );

  assign add_b = iss_fold ? rb_dat : op_data;

  lha_add_pipe #(.WIDTH(WIDTH), .LAT(LATENCY), .TW(IW)) u_add (
    .clk(clk), .rst_n(rst_n), .in_vld(iss_vld), .in_a(ra_dat), .in_b(add_b),
    .in_tag(rd_a_idx), .out_vld(wb_vld), .out_sum(wb_dat), .out_tag(wb_idx),
    .busy(pipe_busy)
  );

  lha_slot_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wb_vld(wb_vld), .wb_idx(wb_idx),
    .wb_dat(wb_dat), .ra_idx(rd_a_idx), .rb_idx(rd_b_idx), .ra_dat(ra_dat),
    .rb_dat(rb_dat), .head_dat(sum_data), .all_zero(all_zero)
  );

  // R4
  last_closes_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && op_last |=> !op_ready);
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid && !sum_ready |=> sum_valid && $stable(sum_data));
  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid && sum_ready |=> op_ready && !sum_valid && all_zero);
  // R10
  drained_before_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_valid) |-> !pipe_busy);
endmodule

// File: tb/test_lat_hide_accum.sv
module test_lat_hide_accum;
  localparam int W = 32, LAT = 7, DEP = 8, NV = 6;
  // stimulus: operand i = base + step*i, an idle cycle after every gap operands
  localparam logic [31:0] V_BASE [NV] = '{32'd5, 32'd42, 32'hFFFF_FFF0, 32'd1000, 32'd0, 32'd77};
  localparam logic [31:0] V_STEP [NV] = '{32'd3, 32'd0, 32'h1000_0001, 32'd7, 32'd1, 32'hFFFF_FFFF};
  localparam int V_LEN [NV] = '{12, 1, 9, 20, 8, 7};   // R6 len 1, R9 len 20 and 8
  localparam int V_GAP [NV] = '{0, 0, 0, 3, 0, 2};     // R8 gaps

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_last = 0, sum_ready = 0;
  logic [W-1:0] op_data = '0;
  logic op_ready, sum_valid;
  logic [W-1:0] sum_data;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lat_hide_accum #(.WIDTH(W), .LATENCY(LAT), .DEPTH(DEP)) i_lat_hide_accum (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_data(op_data), .op_last(op_last), .sum_valid(sum_valid),
    .sum_ready(sum_ready), .sum_data(sum_data));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [31:0] base, input logic [31:0] step, input int len, input int gap);
    logic [31:0] exp = '0;
    logic [31:0] held;
    int sent = 0, lat = 0;
    bit need_idle = 0, stalled = 0, reopened = 0, dropped = 0;
    for (int i = 0; i < len; i++) exp = exp + base + step * i;
    while (sent < len) begin
      @(negedge clk);
      if (need_idle) begin
        op_valid = 0; op_last = 0; need_idle = 0;
      end else begin
        op_valid = 1; op_data = base + step * sent; op_last = (sent == len - 1);
        if (!op_ready) stalled = 1;
        @(posedge clk);
        if (op_ready) begin
          sent++;
          if (gap != 0 && (sent % gap) == 0) need_idle = 1;
        end
      end
    end
    while (lat < 200) begin
      @(negedge clk);
      op_valid = 0; op_last = 0;
      if (sum_valid) break;
      if (op_ready) reopened = 1;
      lat++;
    end
    check(!stalled, "R3 ready during accumulation", 32'(stalled), 32'd0);
    check(!reopened, "R4 input closed after last", 32'(reopened), 32'd0);
    check(lat >= LAT && lat <= 64, "R10 result timing", 32'(lat), 32'(LAT));
    held = sum_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (!sum_valid || sum_data != held) dropped = 1;
      if (op_ready) reopened = 1;
    end
    check(!dropped, "R5 result held", sum_data, held);
    check(!reopened, "R4 input closed while result pending", 32'(reopened), 32'd0);
    if (len == 1)
      check(sum_data == base, "R6 single operand", sum_data, base);
    else if (len >= DEP)
      check(sum_data == exp, "R9 long reduction sum", sum_data, exp);
    else
      check(sum_data == exp, "R2 reduction sum", sum_data, exp);
    if (gap != 0) check(sum_data == exp, "R8 idle cycles ignored", sum_data, exp);
    sum_ready = 1;
    @(posedge clk);
    @(negedge clk);
    sum_ready = 0;
    check(!sum_valid && op_ready, "R7 restart after accept", {sum_valid, op_ready}, 32'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!sum_valid && op_ready, "R1 reset state", {sum_valid, op_ready}, 32'b01);
    for (int v = 0; v < NV; v++) run_vec(V_BASE[v], V_STEP[v], V_LEN[v], V_GAP[v]);
    // R1 reset mid-reduction: partial operands must be forgotten
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); op_valid = 1; op_data = 32'd900 + i; op_last = 0;
    end
    @(negedge clk); op_valid = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!sum_valid && op_ready, "R1 state after mid-run reset", {sum_valid, op_ready}, 32'b01);
    run_vec(32'd10, 32'd10, 3, 0);   // expect 60 with no leftover
    // R7 back-to-back reductions stay independent
    run_vec(32'd1, 32'd0, 2, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule